// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit takes one operand and a bit number, reports whether the addressed bit was clear, and can also force that bit to one, force it to zero or invert it. It serves the execute stage of an integer core. Decode supplies the operation, the operand kind and a bit number, which may come from an instruction field or from a data register. Memory access sits outside the block: a memory operand arrives as a byte in the low lanes of the operand bus, and the modified byte leaves the same way, together with a write request.

The operand kind sets the width. Register operands are 32 bits wide and memory operands are 8 bits wide, and the bit number wraps around that width. Only the zero flag of the condition codes changes. The extend, negative, overflow and carry flags leave the unit as they came in. All outputs are registered, so a request presented on one rising edge appears on the outputs after that edge.

Top module: `bitop_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs `out_valid`, `wr_en`, `result` and `flags_out` are all zero after that edge.
- R2: A request with `in_valid` high at a rising edge gives `out_valid` = 1 after that edge. An edge with `in_valid` low gives `out_valid` = 0 and `wr_en` = 0.
- R3: For a register operand (`is_mem` = 0), only `bit_sel[4:0]` selects the bit. Higher bits of `bit_sel` are ignored.
- R4: For a memory operand (`is_mem` = 1), only `bit_sel[2:0]` selects the bit within `operand[7:0]`, and `result[31:24..8]`, that is `result[31:8]`, is zero.
- R5: `flags_out[2]` (zero flag) is 1 exactly when the selected bit of the operand was 0 before any modification. This holds for every operation.
- R6: Operation code 2'b00 (test) returns the operand unchanged (zero-extended byte for memory) and gives `wr_en` = 0.
- R7: Operation code 2'b11 (set) returns the operand with the selected bit forced to 1.
- R8: Operation code 2'b10 (clear) returns the operand with the selected bit forced to 0.
- R9: Operation code 2'b01 (change) returns the operand with the selected bit inverted.
- R10: The `flags_out` bits [4] extend, [3] negative, [1] overflow and [0] carry equal the corresponding bits of `flags_in` from the same request.
- R11: `wr_en` is 1 exactly when `out_valid` is 1 and the operation is set, clear or change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 2 | 00 test, 01 change, 10 clear, 11 set |
| is_mem | input | 1 | 1: byte memory operand, 0: 32-bit register operand |
| bit_sel | input | 8 | Bit number, taken modulo the operand width |
| operand | input | 32 | Operand value (byte in [7:0] for memory) |
| flags_in | input | 5 | Condition codes {X,N,Z,V,C} before the operation |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Modified operand |
| flags_out | output | 5 | Condition codes with Z updated |
| wr_en | output | 1 | Result must be written back |

## Verification
Wrong internal state in this unit has only two places to live: the selected index and the output register. A mis-wrapped index shows up one cycle after the request in two ways. A stray bit flips in `result` away from the expected position, and `flags_out[2]` disagrees with the original bit. A write-enable or valid that sticks past its request is visible on the very next idle cycle. The stimulus therefore uses bit numbers above the operand width, at the top bit and at zero, and follows each request with an idle cycle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        OP_TEST = 2'b00,
        OP_CHG  = 2'b01,
        OP_CLR  = 2'b10,
        OP_SET  = 2'b11
    } bitop_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    localparam int CCR_W = 5;

    function automatic logic is_modify(input bitop_e o);
        return o != OP_TEST;
    endfunction

    function automatic ccr_t merge_zero(input ccr_t f, input logic zero);
        ccr_t r;
        r   = f;
        r.z = zero;
        return r;
    endfunction

endpackage

// File: rtl/bitop_index.sv
module bitop_index #(
    parameter int DATA_W = 32,
    parameter int MEM_W  = 8,
    parameter int SEL_W  = 8
) (
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              is_mem,
    output logic [DATA_W-1:0] mask
);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int MIDX_W = $clog2(MEM_W);

    logic [IDX_W-1:0] idx;

    always_comb begin
        if (is_mem)
            idx = IDX_W'(bit_sel[MIDX_W-1:0]);
        else
            idx = bit_sel[IDX_W-1:0];
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_dec
        assign mask[i] = (idx == IDX_W'(i));
    end
endmodule

// File: rtl/bitop_modify.sv
module bitop_modify
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MEM_W  = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] mask,
    input  logic              is_mem,
    input  bitop_e            op,
    output logic [DATA_W-1:0] value,
    output logic              was_zero
);
    logic [DATA_W-1:0] lanes;

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        if (i < MEM_W) begin : g_low
            assign lanes[i] = operand[i];
        end else begin : g_high
            assign lanes[i] = operand[i] & ~is_mem;
        end
    end

    assign was_zero = ~|(lanes & mask);

    always_comb begin
        unique case (op)
            OP_SET:  value = lanes | mask;
            OP_CLR:  value = lanes & ~mask;
            OP_CHG:  value = lanes ^ mask;
            default: value = lanes;
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MEM_W  = 8,
    parameter int SEL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic              is_mem,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [CCR_W-1:0]  flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [CCR_W-1:0]  flags_out,
    output logic              wr_en
);
    bitop_e            op_q;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] value;
    logic              was_zero;
    ccr_t              ccr_next;

    assign op_q = bitop_e'(op);

    bitop_index #(.DATA_W(DATA_W), .MEM_W(MEM_W), .SEL_W(SEL_W)) u_index (
        .bit_sel (bit_sel),
        .is_mem  (is_mem),
        .mask    (mask)
    );

    bitop_modify #(.DATA_W(DATA_W), .MEM_W(MEM_W)) u_modify (
        .operand  (operand),
        .mask     (mask),
        .is_mem   (is_mem),
        .op       (op_q),
        .value    (value),
        .was_zero (was_zero)
    );

    assign ccr_next = merge_zero(ccr_t'(flags_in), was_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            result    <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid & is_modify(op_q);
            if (in_valid) begin
                result    <= value;
                flags_out <= ccr_next;
            end
        end
    end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int DATA_W = 32,
    parameter int MEM_W  = 8,
    parameter int SEL_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        op,
    input logic              is_mem,
    input logic [SEL_W-1:0]  bit_sel,
    input logic [DATA_W-1:0] operand,
    input logic [4:0]        flags_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [4:0]        flags_out,
    input logic              wr_en
);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int MIDX_W = $clog2(MEM_W);

    logic [DATA_W-1:0] p_opnd;
    logic [1:0]        p_op;
    logic              p_mem;
    logic [SEL_W-1:0]  p_sel;
    logic [4:0]        p_flags;
    logic [IDX_W-1:0]  p_idx;
    logic [DATA_W-1:0] p_base;

    always_ff @(posedge clk) begin
        p_opnd  <= operand;
        p_op    <= op;
        p_mem   <= is_mem;
        p_sel   <= bit_sel;
        p_flags <= flags_in;
    end

    assign p_idx  = p_mem ? IDX_W'(p_sel[MIDX_W-1:0]) : p_sel[IDX_W-1:0];
    assign p_base = p_mem ? DATA_W'(p_opnd[MEM_W-1:0]) : p_opnd;

    // R11
    wr_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> out_valid);

    // R11
    wr_matches_op_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (wr_en == (p_op != 2'b00)));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags_out[2] == ~p_base[p_idx]));

    // R10
    other_flags_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags_out[4:3] == p_flags[4:3] && flags_out[1:0] == p_flags[1:0]));

    // R4
    mem_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && p_mem) |-> (result[DATA_W-1:MEM_W] == '0));

    // R6
    test_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && p_op == 2'b00) |-> (result == p_base));

    // R3
    one_bit_touched_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(result ^ p_base) <= 1));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .MEM_W(MEM_W), .SEL_W(SEL_W)) u_bitop_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .is_mem    (is_mem),
    .bit_sel   (bit_sel),
    .operand   (operand),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out),
    .wr_en     (wr_en)
);

// File: tb/test_bitop_unit.sv
module test_bitop_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic        is_mem;
    logic [7:0]  bit_sel;
    logic [31:0] operand;
    logic [4:0]  flags_in;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  flags_out;
    logic        wr_en;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    bitop_unit i_bitop_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .is_mem(is_mem),
        .bit_sel(bit_sel), .operand(operand), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .flags_out(flags_out), .wr_en(wr_en)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        mem;
        logic [7:0]  sel;
        logic [31:0] opnd;
        logic [4:0]  fl;
        logic [31:0] exp_res;
        logic        exp_z;
        logic        exp_we;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{2'b00, 1'b0, 8'd0,   32'h0000_0001, 5'b10101, 32'h0000_0001, 1'b0, 1'b0}, // R6
        '{2'b00, 1'b0, 8'd31,  32'h7FFF_FFFF, 5'b01010, 32'h7FFF_FFFF, 1'b1, 1'b0}, // R6 R5
        '{2'b11, 1'b0, 8'd4,   32'h0000_0000, 5'b11111, 32'h0000_0010, 1'b1, 1'b1}, // R7
        '{2'b11, 1'b0, 8'd36,  32'h0000_0010, 5'b00000, 32'h0000_0010, 1'b0, 1'b1}, // R7 R3
        '{2'b10, 1'b0, 8'h1F,  32'hFFFF_FFFF, 5'b10011, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R8
        '{2'b10, 1'b0, 8'd3,   32'h0000_00F0, 5'b01100, 32'h0000_00F0, 1'b1, 1'b1}, // R8 R5
        '{2'b01, 1'b0, 8'd16,  32'h1234_5678, 5'b11001, 32'h1235_5678, 1'b1, 1'b1}, // R9
        '{2'b01, 1'b0, 8'hE5,  32'h0000_0020, 5'b00110, 32'h0000_0000, 1'b0, 1'b1}, // R9 R3
        '{2'b11, 1'b1, 8'd9,   32'hABCD_EF00, 5'b10000, 32'h0000_0002, 1'b1, 1'b1}, // R4 R7
        '{2'b10, 1'b1, 8'd7,   32'h0000_00FF, 5'b01001, 32'h0000_007F, 1'b0, 1'b1}, // R4 R8
        '{2'b01, 1'b1, 8'hFF,  32'h1122_3380, 5'b11011, 32'h0000_0000, 1'b0, 1'b1}, // R4 R9
        '{2'b00, 1'b1, 8'd12,  32'hFFFF_FF00, 5'b00101, 32'h0000_0000, 1'b1, 1'b0}  // R4 R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0;
        op       = 2'b00;
        is_mem   = 1'b0;
        bit_sel  = '0;
        operand  = '0;
        flags_in = '0;
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1;
        op       = v.op;
        is_mem   = v.mem;
        bit_sel  = v.sel;
        operand  = v.opnd;
        flags_in = v.fl;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 wr_en", 32'(wr_en), 0);
        check("R1 result", result, 0);
        check("R1 flags_out", 32'(flags_out), 0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            logic [4:0] ef;
            issue(TBL[k]);
            ef = {TBL[k].fl[4:3], TBL[k].exp_z, TBL[k].fl[1:0]};
            check("R2 out_valid", 32'(out_valid), 1);
            check("R6-R9 result", result, TBL[k].exp_res);
            check("R5 zero flag", 32'(flags_out[2]), 32'(TBL[k].exp_z));
            check("R10 flags", 32'(flags_out), 32'(ef));
            check("R11 wr_en", 32'(wr_en), 32'(TBL[k].exp_we));
            @(negedge clk);
            // R2 idle cycle quiets valid and write
            check("R2 idle out_valid", 32'(out_valid), 0);
            check("R11 idle wr_en", 32'(wr_en), 0);
        end

        // R3: high bit_sel bits ignored, set bit 0 via 8'hE0
        issue('{2'b11, 1'b0, 8'hE0, 32'h8000_0000, 5'b00000, 32'h8000_0001, 1'b1, 1'b1});
        check("R3 high sel ignored", result, 32'h8000_0001);
        // R4: bit_sel 8'h0F on memory selects bit 7
        issue('{2'b01, 1'b1, 8'h0F, 32'hFFFF_FF7F, 5'b00000, 32'h0000_00FF, 1'b1, 1'b1});
        check("R4 mem index wrap", result, 32'h0000_00FF);
        check("R5 mem zero", 32'(flags_out[2]), 1);

        // back-to-back requests
        @(negedge clk);
        in_valid = 1'b1; op = 2'b10; is_mem = 1'b0; bit_sel = 8'd1; operand = 32'h0000_0003; flags_in = 5'b11111;
        @(negedge clk);
        check("R8 b2b first", result, 32'h0000_0001);
        op = 2'b00; bit_sel = 8'd2;
        @(negedge clk);
        idle_inputs();
        check("R6 b2b second", result, 32'h0000_0003);
        check("R11 b2b test wr", 32'(wr_en), 0);
        check("R5 b2b second z", 32'(flags_out[2]), 1);

        // R1: reset mid-stream
        @(negedge clk);
        in_valid = 1'b1; op = 2'b11; operand = 32'h0; bit_sel = 8'd5;
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset valid", 32'(out_valid), 0);
        check("R1 mid reset result", result, 0);
        check("R1 mid reset wr", 32'(wr_en), 0);
        idle_inputs();
        rst = 1'b0;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule